// File: doc/BRIEF.md
# Debounced Edge-Selected Key Port Interrupt

This block sits behind an 8-pin input port used for keys and switches. It takes the raw pin levels into the clock domain and removes contact bounce. From the cleaned levels it raises one interrupt request for the whole port. The pins form two groups of four, a lower and an upper group. Each group has its own 3-bit filter code. Code zero passes the levels straight through. Any other code sets a check time that is a power of two in clock cycles. A level is only accepted once it has stayed put for between one and two check times.

Every cleaned pin has three controls: an edge-select bit, a sticky flag and an enable bit. The edge-select bit decides whether a rising or a falling transition sets the flag. Software clears a flag by writing one to its bit. The enable bit only gates whether the flag reaches the shared request line. Configuration goes through a small write-only register port with four addresses. A free-running prescaler supplies the sampling ticks for all filter settings.

Top module: `keyport_irq`

## Requirements
- R1: While and right after reset, flagOut, pinLevel and irq are all zero, and both filter codes are 0.
- R2: When a group's code is 0, its pinLevel bits equal pinIn two clock edges after pinIn changes, and are unchanged after one edge.
- R3: A nonzero code c gives its group a check time T = 2^(BASE_SHIFT+c-1) clock cycles. With the default BASE_SHIFT=8, codes 1..7 give 256..16384 cycles.
- R4: When pins stay stable, a pulse that lasts T cycles or fewer never changes pinLevel and never sets a flag.
- R5: After a pin changes and then holds its new level, pinLevel still shows the old level T cycles later. It shows the new level no later than 2T+4 cycles after the change.
- R6: One edge after a pinLevel bit changes, its flag is set if the change matches the bit's edge select. Edge select 1 picks rising edges and 0 picks falling edges.
- R7: A flag stays set until software writes 1 to its bit at the clear address. Writing 0 to a bit leaves that flag unchanged.
- R8: If a flag clear and a new selected edge arrive for the same bit in the same cycle, the flag ends up set.
- R9: Flags are set whatever the enable bits hold. irq is high exactly when some flag and its enable bit are both 1.
- R10: The register addresses are: 0 for filter codes (wrData[2:0] is the lower group, wrData[6:4] is the upper group), 1 for edge select, 2 for enable, and 3 for clearing flags. A write is taken on a clock edge where wrEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | PORT_W | Raw port pin levels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | PORT_W | Register write data |
| pinLevel | output | PORT_W | Synchronized, filtered pin levels |
| flagOut | output | PORT_W | Sticky per-pin interrupt flags |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench builds the block with BASE_SHIFT=2, so codes 1 to 7 give check times of 4 to 256 cycles. At this scale every code can be used many times within the cycle limit. The bench gives the two groups different codes, so the split between the groups is tested in the same run. Glitch widths are drawn up to the full check time, and the accept and reject bounds are sampled at their exact cycle limits. Three ordering cases are driven directly: a clear and an edge on the same bit in the same cycle, flags set while their enable bits are off, and falling-edge selection on one group while the other group selects rising edges.

// File: rtl/keyport_pkg.sv
package keyport_pkg;

  localparam int ADDR_CODE = 0;
  localparam int ADDR_EDGE = 1;
  localparam int ADDR_MASK = 2;
  localparam int ADDR_CLR  = 3;

  // one-cycle register strobes from control to datapath
  typedef struct packed {
    logic ldCode;
    logic ldEdge;
    logic ldMask;
    logic clrFlag;
  } regStrobe_t;

  // per-group filter control
  typedef struct packed {
    logic tick;
    logic bypass;
  } grpCtl_t;

endpackage

// File: rtl/keyport_ctrl.sv
module keyport_ctrl
  import keyport_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int NGRP       = 2,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 8,
  parameter int ADDR_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [PORT_W-1:0]    wrData,
  output regStrobe_t           strobe,
  output grpCtl_t [NGRP-1:0]   grpCtl
);

  localparam int FIELD_STRIDE = PORT_W / NGRP;
  localparam int NCODE        = 1 << CODE_W;
  localparam int PRE_W        = BASE_SHIFT + NCODE - 2;

  logic [NGRP-1:0][CODE_W-1:0] codeQ;
  logic [PRE_W-1:0]            preCnt;
  logic [NCODE-1:0]            tickByCode;

  always_comb begin
    strobe.ldCode  = wrEn && (wrAddr == ADDR_W'(ADDR_CODE));
    strobe.ldEdge  = wrEn && (wrAddr == ADDR_W'(ADDR_EDGE));
    strobe.ldMask  = wrEn && (wrAddr == ADDR_W'(ADDR_MASK));
    strobe.clrFlag = wrEn && (wrAddr == ADDR_W'(ADDR_CLR));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickByCode[0] = 1'b0;

  // code c ticks once every 2^(BASE_SHIFT+c-1) cycles
  for (genvar c = 1; c < NCODE; c++) begin : g_tick
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << (BASE_SHIFT + c - 1)) - 64'd1);
    assign tickByCode[c] = ((preCnt & MASK) == MASK);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              codeQ[g] <= '0;
      else if (strobe.ldCode) codeQ[g] <= wrData[g*FIELD_STRIDE +: CODE_W];
    end
    assign grpCtl[g].tick   = tickByCode[codeQ[g]];
    assign grpCtl[g].bypass = (codeQ[g] == '0);
  end

endmodule

// File: rtl/keyport_dp.sv
module keyport_dp
  import keyport_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NGRP   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PORT_W-1:0]  pinIn,
  input  logic [PORT_W-1:0]  wrData,
  input  regStrobe_t         strobe,
  input  grpCtl_t [NGRP-1:0] grpCtl,
  output logic [PORT_W-1:0]  pinLevel,
  output logic [PORT_W-1:0]  flagOut,
  output logic               irq,
  output logic [PORT_W-1:0]  syncLvl
);

  localparam int GRP_W = PORT_W / NGRP;

  logic [PORT_W-1:0] syncA, syncB;
  logic [PORT_W-1:0] prevQ, edgeQ, maskQ, flagQ;
  logic [PORT_W-1:0] riseV, fallV, setV, clrV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign syncLvl = syncB;

  for (genvar g = 0; g < NGRP; g++) begin : g_filt
    logic [GRP_W-1:0] sampQ, filtQ, inV, agree;
    assign inV   = syncB[g*GRP_W +: GRP_W];
    assign agree = ~(inV ^ sampQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampQ <= '0;
        filtQ <= '0;
      end else if (grpCtl[g].bypass) begin
        sampQ <= inV;
        filtQ <= inV;
      end else if (grpCtl[g].tick) begin
        sampQ <= inV;
        filtQ <= (filtQ & ~agree) | (inV & agree);
      end
    end

    assign pinLevel[g*GRP_W +: GRP_W] = grpCtl[g].bypass ? inV : filtQ;
  end

  assign riseV = pinLevel & ~prevQ;
  assign fallV = ~pinLevel & prevQ;
  assign setV  = (edgeQ & riseV) | (~edgeQ & fallV);
  assign clrV  = strobe.clrFlag ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      edgeQ <= '0;
      maskQ <= '0;
      flagQ <= '0;
    end else begin
      prevQ <= pinLevel;
      if (strobe.ldEdge) edgeQ <= wrData;
      if (strobe.ldMask) maskQ <= wrData;
      flagQ <= (flagQ & ~clrV) | setV;
    end
  end

  assign flagOut = flagQ;
  assign irq     = |(flagQ & maskQ);

endmodule

// File: rtl/keyport_irq.sv
module keyport_irq
  import keyport_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int NGRP       = 2,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 8,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] pinLevel,
  output logic [PORT_W-1:0] flagOut,
  output logic              irq
);

  regStrobe_t         strobe;
  grpCtl_t [NGRP-1:0] grpCtl;
  logic [PORT_W-1:0]  syncLvl;
  logic [NGRP-1:0]    bypassVec;

  keyport_ctrl #(
    .PORT_W(PORT_W), .NGRP(NGRP), .CODE_W(CODE_W),
    .BASE_SHIFT(BASE_SHIFT), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .grpCtl(grpCtl)
  );

  keyport_dp #(.PORT_W(PORT_W), .NGRP(NGRP)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrData(wrData),
    .strobe(strobe), .grpCtl(grpCtl), .pinLevel(pinLevel),
    .flagOut(flagOut), .irq(irq), .syncLvl(syncLvl)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_byp
    assign bypassVec[g] = grpCtl[g].bypass;
  end

endmodule

// File: rtl/keyport_chk.sv
module keyport_chk
  import keyport_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NGRP   = 2,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [PORT_W-1:0] pinLevel,
  input logic [PORT_W-1:0] flagOut,
  input logic              irq,
  input logic [PORT_W-1:0] syncLvl,
  input logic [NGRP-1:0]   bypassVec
);

  localparam int GRP_W = PORT_W / NGRP;

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagOut != '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_W'(ADDR_CLR)) |=> ((flagOut & $past(flagOut)) == $past(flagOut)));

  // R6
  flag_after_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagOut & ~$past(flagOut)) != '0) |-> ($past(pinLevel) != $past(pinLevel, 2)));

  for (genvar g = 0; g < NGRP; g++) begin : g_filt
    // R4
    filter_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!bypassVec[g] && !$past(bypassVec[g]) &&
       pinLevel[g*GRP_W +: GRP_W] != $past(pinLevel[g*GRP_W +: GRP_W]))
      |-> (pinLevel[g*GRP_W +: GRP_W] == $past(syncLvl[g*GRP_W +: GRP_W])));
  end

endmodule

bind keyport_irq keyport_chk #(.PORT_W(PORT_W), .NGRP(NGRP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .pinLevel(pinLevel),
  .flagOut(flagOut), .irq(irq), .syncLvl(syncLvl), .bypassVec(bypassVec)
);

// File: tb/keyport_irq_tb.sv
`timescale 1ns/1ps
module keyport_irq_tb;

  localparam int BS = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [7:0] pinIn = '0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pinLevel, flagOut;
  logic       irq;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyport_irq #(.BASE_SHIFT(BS)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pinLevel(pinLevel), .flagOut(flagOut), .irq(irq)
  );

  function automatic int tp(input int c);
    return (c == 0) ? 0 : (1 << (BS + c - 1));
  endfunction

  function automatic logic [7:0] edgeSet(input logic [7:0] o, input logic [7:0] n,
                                         input logic [7:0] sel);
    return (sel & n & ~o) | (~sel & ~n & o);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur, nxt, expFlag, edgeSel, enMask, clr, gMask;
    int cLo, cHi, tLo, tHi, tMax, tMin, w;
    void'($urandom(32'h5eed_1234));
    #1 rstN = 1'b0;
    cyc(5);
    chk("R1 flags", flagOut, 8'h00);
    chk("R1 level", pinLevel, 8'h00);
    chk("R1 irq", irq, 1'b0);
    rstN = 1'b1;
    cyc(2);

    // codes default 0: passthrough (R2), rising edges, enables off
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    pinIn = 8'hA5;
    cyc(1); chk("R2 one edge", pinLevel, 8'h00);
    cyc(1); chk("R2 two edges", pinLevel, 8'hA5);
    cyc(1); chk("R6 rising flags", flagOut, 8'hA5);
    chk("R9 gated off", irq, 1'b0);
    wr(2'd2, 8'h01); chk("R9 enabled", irq, 1'b1);
    wr(2'd3, 8'h04); chk("R7 clear one", flagOut, 8'hA1);
    wr(2'd3, 8'h00); chk("R7 zero write", flagOut, 8'hA1);
    wr(2'd3, 8'hFF); chk("R7 clear all", flagOut, 8'h00);
    chk("R9 none", irq, 1'b0);

    // R6 falling on upper group, rising on lower
    wr(2'd1, 8'h0F);
    pinIn = 8'h00;
    cyc(3); chk("R6 falling select", flagOut, 8'hA0);
    wr(2'd3, 8'hFF);

    // R8 set beats clear
    pinIn = 8'h01;
    cyc(2);
    wrEn = 1'b1; wrAddr = 2'd3; wrData = 8'h01;
    cyc(1);
    wrEn = 1'b0;
    chk("R8 set wins", flagOut, 8'h01);
    wr(2'd3, 8'hFF); chk("R7 cleared", flagOut, 8'h00);

    cur = 8'h01; expFlag = 8'h00; edgeSel = 8'h0F; enMask = 8'h01;
    cLo = 0; cHi = 0; tLo = 0; tHi = 0; tMax = 0; tMin = 0;
    for (int it = 0; it < 48; it++) begin
      if (it % 8 == 0) begin
        cLo = (it == 0) ? 1 : $urandom_range(0, 7);
        cHi = (it == 0) ? 7 : $urandom_range(0, 7);
        wr(2'd0, {1'b0, 3'(cHi), 1'b0, 3'(cLo)});
        tLo = tp(cLo); tHi = tp(cHi);
        tMax = (tLo > tHi) ? tLo : tHi;
        tMin = (tLo < tHi) ? tLo : tHi;
        cyc(2 * tMax + 8);
        chk("R10 code write no edge", flagOut, expFlag);
      end
      edgeSel = 8'($urandom); wr(2'd1, edgeSel);
      enMask = 8'($urandom);  wr(2'd2, enMask);
      if ($urandom_range(0, 3) == 0) begin
        clr = 8'($urandom); wr(2'd3, clr);
        expFlag &= ~clr;
        chk("R7 random clear", flagOut, expFlag);
      end
      if (tMin > 0 && $urandom_range(0, 2) == 0) begin
        gMask = 8'($urandom_range(1, 255));
        w = $urandom_range(1, tMin);
        pinIn = cur ^ gMask;
        cyc(w);
        pinIn = cur;
        cyc(2 * tMax + 6);
        chk("R4 glitch level", pinLevel, cur);
        chk("R4 glitch flags", flagOut, expFlag);
      end else begin
        nxt = 8'($urandom);
        pinIn = nxt;
        for (int k = 1; k <= 2 * tMax + 4; k++) begin
          cyc(1);
          if (tLo > 0 && k == tLo) chk("R5 R3 low early", pinLevel[3:0], cur[3:0]);
          if (tHi > 0 && k == tHi) chk("R5 R3 high early", pinLevel[7:4], cur[7:4]);
          if (k == 2 * tLo + 4) chk("R5 R10 low late", pinLevel[3:0], nxt[3:0]);
          if (k == 2 * tHi + 4) chk("R5 R10 high late", pinLevel[7:4], nxt[7:4]);
        end
        cyc(2);
        expFlag |= edgeSet(cur, nxt, edgeSel);
        chk("R6 random flags", flagOut, expFlag);
        chk("R9 random irq", irq, |(expFlag & enMask));
        cur = nxt;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule